// File: doc/BRIEF.md
# Sample Sequencer FIFO Bank

This block holds the conversion results of four sample sequencers, each in its own 16-deep, 32-bit FIFO. A producer pushes a result into lane n and a consumer pops the oldest result of lane n. The lanes share no state. Each lane exposes one packed status word that holds its read pointer, its write pointer, an empty flag and a full flag, so software can see the fill state and pointer positions in a single read.

Data moves in and out through valid-style ports with no back-pressure. A push never stalls. A push into a full lane is dropped and sets that lane's sticky overflow bit. The head of each lane, `pop_data_o`, always shows the entry at the read pointer. A pop request takes that entry. A pop of an empty lane takes nothing: it leaves the pointers alone and sets that lane's sticky underflow bit. Overflow bits are cleared by a write-ones-to-clear strobe. Underflow bits clear only on reset.

Top module: `ssq_fifo_bank`

## Requirements
- R1: After reset every lane status word reads 0x0000_0100: both pointers are zero, only the empty flag is set, and the overflow and underflow vectors are zero.
- R2: A push to a lane that is not full stores the data at the write pointer (status bits [7:4]). It advances that pointer by one modulo 16 and clears the empty flag (status bit 8) on the next cycle.
- R3: When an accepted push, with no pop, makes the write pointer equal to the read pointer, the full flag (status bit 12) is set. Status bits other than [7:0], 8 and 12 always read zero.
- R4: A push to a full lane stores nothing, moves no pointer, and sets overflow bit n for lane n. This holds even when a pop to the same lane happens in the same cycle.
- R5: `pop_data_o` lane n shows the entry at the read pointer (status bits [3:0]). A pop of a non-empty lane advances that pointer modulo 16 and clears the full flag. If the new read pointer equals the write pointer, the empty flag is set.
- R6: A pop of an empty lane leaves both pointers and the flags unchanged and sets underflow bit n.
- R7: Overflow bits are sticky. When `ovf_clr_we_i` is high, each bit with a one in `ovf_clr_mask_i` is cleared and bits with zero in the mask are kept. A new overflow in the same cycle as its clear leaves the bit set.
- R8: An accepted push and an accepted pop to the same lane in one cycle both take effect: both pointers advance and the flags keep their values.
- R9: Activity on one lane never changes the status, data or sticky bits of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 4 | Push strobe per lane |
| push_data_i | input | 128 | Push data, lane n at bits [32n+31:32n] |
| pop_valid_i | input | 4 | Pop strobe per lane |
| pop_data_o | output | 128 | Entry at each lane's read pointer |
| status_o | output | 128 | Packed status word per lane |
| ovf_o | output | 4 | Sticky overflow bits |
| ovf_clr_we_i | input | 1 | Overflow clear strobe |
| ovf_clr_mask_i | input | 4 | Bits of the overflow vector to clear |
| unf_o | output | 4 | Sticky underflow bits |

## Verification
A wrong pointer shows up on the status word in the cycle after the push or pop that moved it. It also shows on `pop_data_o` as soon as the read pointer selects the wrong entry, so every drain is checked entry by entry against the pushed order. A wrong full or empty flag decides whether a later push or pop is accepted. When it is wrong, the pointers stop or run past each other, and the sticky overflow and underflow bits set or stay clear when they should not. That error is visible one cycle after the offending strobe. The bench therefore fills and drains a lane completely, pushes into a full lane and pops an empty one, and watches the untouched lanes throughout.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int unsigned SSQ_LANES = 4;
  localparam int unsigned SSQ_DW    = 32;
  localparam int unsigned SSQ_AW    = 4;
  localparam int unsigned SSQ_SW    = 32;
  localparam int unsigned SSQ_EMPTY_BIT = 8;
  localparam int unsigned SSQ_FULL_BIT  = 12;

  typedef struct packed {
    logic              full;
    logic              empty;
    logic [SSQ_AW-1:0] head;
    logic [SSQ_AW-1:0] tail;
  } lane_state_t;

  function automatic logic [SSQ_SW-1:0] pack_status(input lane_state_t s);
    logic [SSQ_SW-1:0] w;
    w = '0;
    w[SSQ_AW-1:0]        = s.tail;
    w[2*SSQ_AW-1:SSQ_AW] = s.head;
    w[SSQ_EMPTY_BIT]     = s.empty;
    w[SSQ_FULL_BIT]      = s.full;
    return w;
  endfunction
endpackage

// File: rtl/ssq_fifo_lane.sv
module ssq_fifo_lane
  import ssq_pkg::*;
#(
  parameter int unsigned DW = SSQ_DW,
  parameter int unsigned AW = SSQ_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output lane_state_t   state_o,
  output logic          push_drop_o,
  output logic          pop_empty_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q, tail_q, head_d, tail_d;
  logic          full_q, empty_q, full_d, empty_d;
  logic          push_ok, pop_ok;

  assign push_ok     = push_i && !full_q;
  assign pop_ok      = pop_i && !empty_q;
  assign push_drop_o = push_i && full_q;
  assign pop_empty_o = pop_i && empty_q;

  always_comb begin
    head_d  = push_ok ? head_q + AW'(1) : head_q;
    tail_d  = pop_ok  ? tail_q + AW'(1) : tail_q;
    full_d  = full_q;
    empty_d = empty_q;
    unique case ({push_ok, pop_ok})
      2'b10: begin
        empty_d = 1'b0;
        full_d  = (head_d == tail_q);
      end
      2'b01: begin
        full_d  = 1'b0;
        empty_d = (tail_d == head_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[head_q] <= data_i;
  end

  assign data_o        = mem[tail_q];
  assign state_o.full  = full_q;
  assign state_o.empty = empty_q;
  assign state_o.head  = head_q;
  assign state_o.tail  = tail_q;
endmodule

// File: rtl/ssq_sticky_flags.sv
module ssq_sticky_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf_set_i,
  input  logic [N-1:0] unf_set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] ovf_o,
  output logic [N-1:0] unf_o
);
  logic [N-1:0] ovf_q, unf_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      unf_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~clr_eff) | ovf_set_i;
      unf_q <= unf_q | unf_set_i;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/ssq_fifo_bank.sv
module ssq_fifo_bank
  import ssq_pkg::*;
#(
  parameter int unsigned LANES = SSQ_LANES,
  parameter int unsigned DW    = SSQ_DW,
  parameter int unsigned AW    = SSQ_AW,
  parameter int unsigned SW    = SSQ_SW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]    push_valid_i,
  input  logic [LANES*DW-1:0] push_data_i,
  input  logic [LANES-1:0]    pop_valid_i,
  output logic [LANES*DW-1:0] pop_data_o,
  output logic [LANES*SW-1:0] status_o,
  output logic [LANES-1:0]    ovf_o,
  input  logic               ovf_clr_we_i,
  input  logic [LANES-1:0]    ovf_clr_mask_i,
  output logic [LANES-1:0]    unf_o
);
  logic [LANES-1:0] drop_vec, empty_pop_vec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_state_t st;
    ssq_fifo_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_valid_i[g]),
      .data_i      (push_data_i[g*DW +: DW]),
      .pop_i       (pop_valid_i[g]),
      .data_o      (pop_data_o[g*DW +: DW]),
      .state_o     (st),
      .push_drop_o (drop_vec[g]),
      .pop_empty_o (empty_pop_vec[g])
    );
    assign status_o[g*SW +: SW] = pack_status(st);
  end

  ssq_sticky_flags #(.N(LANES)) u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_set_i  (drop_vec),
    .unf_set_i  (empty_pop_vec),
    .clr_we_i   (ovf_clr_we_i),
    .clr_mask_i (ovf_clr_mask_i),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );
endmodule

// File: rtl/ssq_fifo_bank_chk.sv
module ssq_fifo_bank_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned SW    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LANES-1:0]    push_valid_i,
  input logic [LANES*DW-1:0] push_data_i,
  input logic [LANES-1:0]    pop_valid_i,
  input logic [LANES*DW-1:0] pop_data_o,
  input logic [LANES*SW-1:0] status_o,
  input logic [LANES-1:0]    ovf_o,
  input logic               ovf_clr_we_i,
  input logic [LANES-1:0]    ovf_clr_mask_i,
  input logic [LANES-1:0]    unf_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic [SW-1:0] s;
    assign s = status_o[g*SW +: SW];

    // R3: flags never both set, reserved bits zero
    p_flags_sane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(s[12] && s[8]) && (s[SW-1:13] == '0) && (s[11:9] == '0));

    p_push_clears_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_i[g] && !s[12] && !pop_valid_i[g]) |=> !status_o[g*SW+8]);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid_i[g] && s[12] && !pop_valid_i[g]) |=>
        (ovf_o[g] && $stable(status_o[g*SW +: 8])));

    p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid_i[g] && !s[8] && !push_valid_i[g]) |=> !status_o[g*SW+12]);

    p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid_i[g] && s[8] && !push_valid_i[g]) |=>
        (unf_o[g] && $stable(status_o[g*SW +: SW])));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o[g] && !(ovf_clr_we_i && ovf_clr_mask_i[g])) |=> ovf_o[g]);

    p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o[g] |=> unf_o[g]);
  end
endmodule

bind ssq_fifo_bank ssq_fifo_bank_chk #(.LANES(LANES), .DW(DW), .SW(SW)) u_chk (.*);

// File: tb/ssq_fifo_bank_bench.sv
`timescale 1ns/1ps
module ssq_fifo_bank_bench;
  localparam int L = 4;
  localparam int DW = 32;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0]    push_valid = '0;
  logic [L*DW-1:0] push_data = '0;
  logic [L-1:0]    pop_valid = '0;
  logic [L*DW-1:0] pop_data;
  logic [L*SW-1:0] status;
  logic [L-1:0]    ovf, unf;
  logic            clr_we = 1'b0;
  logic [L-1:0]    clr_mask = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ssq_fifo_bank u_ssq_fifo_bank (
    .clk(clk), .rst_n(rst_n),
    .push_valid_i(push_valid), .push_data_i(push_data),
    .pop_valid_i(pop_valid), .pop_data_o(pop_data),
    .status_o(status), .ovf_o(ovf),
    .ovf_clr_we_i(clr_we), .ovf_clr_mask_i(clr_mask), .unf_o(unf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input int n);
    return status[n*SW +: SW];
  endfunction

  function automatic logic [31:0] hd(input int n);
    return pop_data[n*DW +: DW];
  endfunction

  // one cycle of stimulus, driven at negedge, results sampled at next negedge
  task automatic cyc(input logic [L-1:0] pu, input logic [L-1:0] po, input logic [31:0] d);
    push_valid = pu;
    pop_valid  = po;
    for (int i = 0; i < L; i++) push_data[i*DW +: DW] = d + 32'(i);
    @(negedge clk);
    push_valid = '0;
    pop_valid  = '0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < L; i++) chk("R1 status", st(i), 32'h100);
    chk("R1 ovf", {28'd0, ovf}, 0);
    chk("R1 unf", {28'd0, unf}, 0);
  endtask

  task automatic t_fill;
    cyc(4'b0001, 4'b0000, 32'hA000_0000);
    chk("R2 first push", st(0), 32'h010);
    chk("R2 head data", hd(0), 32'hA000_0000);
    chk("R9 lane1 untouched", st(1), 32'h100);
    for (int k = 1; k < 16; k++) begin
      cyc(4'b0001, 4'b0000, 32'hA000_0000 + 32'(k) * 16);
      if (k == 14) chk("R2 head 15", st(0), 32'h0F0);
    end
    chk("R3 full after 16", st(0), 32'h1000);
    chk("R3 no ovf yet", {28'd0, ovf}, 0);
  endtask

  task automatic t_overflow;
    cyc(4'b0001, 4'b0000, 32'hDEAD_0000);
    chk("R4 ptrs kept", st(0), 32'h1000);
    chk("R4 ovf set", {28'd0, ovf}, 32'h1);
    chk("R4 head data kept", hd(0), 32'hA000_0000);
  endtask

  task automatic t_drain;
    for (int k = 0; k < 16; k++) begin
      chk("R5 pop order", hd(0), 32'hA000_0000 + 32'(k) * 16);
      cyc(4'b0000, 4'b0001, 0);
      if (k == 0) chk("R5 first pop", st(0), 32'h001);
    end
    chk("R5 empty after drain", st(0), 32'h100);
    chk("R9 unf untouched", {28'd0, unf}, 0);
  endtask

  task automatic t_underflow;
    cyc(4'b0000, 4'b0010, 0);
    chk("R6 ptrs kept", st(1), 32'h100);
    chk("R6 unf set", {28'd0, unf}, 32'h2);
  endtask

  task automatic t_ovf_clear;
    clr_we = 1'b1; clr_mask = 4'b0000;
    @(negedge clk);
    chk("R7 zero mask keeps", {28'd0, ovf}, 32'h1);
    clr_mask = 4'b1110;
    @(negedge clk);
    chk("R7 other bits keep", {28'd0, ovf}, 32'h1);
    clr_mask = 4'b0001;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    chk("R7 cleared", {28'd0, ovf}, 0);
  endtask

  task automatic t_simul;
    cyc(4'b0100, 4'b0000, 32'h5000_0000);
    chk("R8 setup", st(2), 32'h010);
    chk("R8 head before", hd(2), 32'h5000_0002);
    cyc(4'b0100, 4'b0100, 32'h6000_0000);
    chk("R8 both moved", st(2), 32'h021);
    chk("R8 new head data", hd(2), 32'h6000_0002);
    chk("R9 lane3 untouched", st(3), 32'h100);
    chk("R9 sticky untouched", {24'd0, unf, ovf}, 32'h20);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_overflow();
    t_drain();
    t_underflow();
    t_ovf_clear();
    t_simul();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule